// File: doc/BRIEF.md
# Shared Lock Bank for Multiple Cores

This block holds a set of hardware locks that several processor cores share. Each core has its own request port. A write of 1 to a lock index asks to claim that lock. A write of 0 asks to give the lock back. A read asks whether the reading core currently holds that lock. Inside the block, each lock keeps a held bit and the binary index of the core that holds it.

The locks sit in the device-register window at the top of the data address space, from FC00 to FFFF. The surrounding bus fabric decodes that window and passes only the lock index to this block. Reads answer one clock after the request on a registered response pair. Writes give no response; a core that wants to know whether its claim worked reads the lock afterwards.

If two or more cores try to claim the same free lock in one cycle, the core with the lowest index wins. A release takes effect only when it comes from the current holder.

Top module: `mutex_bank`

## Requirements
- R1: After reset every lock is free with no holder, and every core that reads any lock gets 0. While reset is asserted, the response valid and data outputs are 0.
- R2: A write of 1 to a free lock makes the writing core its holder.
- R3: A write of 1 to a lock that another core holds leaves the holder unchanged.
- R4: A write of 1 from the core that already holds a lock keeps that core as holder.
- R5: A write of 0 from the holder frees the lock, after which another core can claim it.
- R6: A write of 0 from a core that does not hold the lock is ignored, and the holder keeps the lock.
- R7: A read returns 1 only when the reading core holds the lock. It returns 0 when the lock is free or when another core holds it.
- R8: When several cores write 1 to the same free lock in one cycle, the lowest-numbered core becomes the holder.
- R9: A read issued in the cycle right after a successful claim returns 1 for the claiming core.
- R10: The response valid of a core is 1 exactly one cycle after that core issues a read (valid=1, write=0). It is 0 after writes and after idle cycles.
- R11: A claim is judged against the lock state at the start of the cycle. So if the holder releases a lock in the same cycle that another core tries to claim it, the lock ends the cycle free.
- R12: Locks are independent. Requests to different indices in the same cycle are all served, and an operation on one lock does not change any other lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| coreValid | input | NumCores | Request valid, one bit per core |
| coreWrite | input | NumCores | 1 = write request, 0 = read request |
| coreWData | input | NumCores | Write data bit: 1 = claim, 0 = release |
| coreIndex | input | NumCores*IxW | Lock index per core; core c uses bits [c*IxW +: IxW] |
| coreRValid | output | NumCores | Read response valid, one cycle after a read |
| coreRData | output | NumCores | Read response: 1 if the core held the lock when it read |

## Verification
Two events can land on the same lock in the same cycle: the holder releasing it, and a different core trying to claim it. The bench sets this up by having core 1 release lock 5 while core 3 writes 1 to lock 5, and core 0 reads lock 5 in that same cycle. Reads in the next cycle must show that neither core 1 nor core 3 holds the lock, and a later claim by core 3 must succeed. A second kind of overlap is several claims to one free lock in one cycle; this is judged by reading the lock back from every core and checking that only the lowest-numbered claimant reads 1.

// File: rtl/mutex_pkg.sv
package mutex_pkg;

  // Default size of the bank
  localparam int unsigned MTX_CORES_DEF = 4;
  localparam int unsigned MTX_LOCKS_DEF = 8;

  // Widest holder id the strobe struct can carry (up to 256 cores)
  localparam int unsigned OWNER_W_MAX = 8;

  // Per-lock update strobe from control to datapath
  typedef struct packed {
    logic                   take;  // set held, load holder id
    logic                   drop;  // clear held, clear holder id
    logic [OWNER_W_MAX-1:0] who;   // winning core for a take
  } lockStrobe_t;

endpackage

// File: rtl/mutex_ctrl.sv
module mutex_ctrl
  import mutex_pkg::*;
#(
  parameter int unsigned NumCores = MTX_CORES_DEF,
  parameter int unsigned NumLocks = MTX_LOCKS_DEF,
  parameter int unsigned IdW      = 2,
  parameter int unsigned IxW      = 3
) (
  input  logic [NumCores-1:0]     coreValid,
  input  logic [NumCores-1:0]     coreWrite,
  input  logic [NumCores-1:0]     coreWData,
  input  logic [NumCores*IxW-1:0] coreIndex,
  input  logic [NumLocks-1:0]     lockHeld,
  input  logic [NumLocks*IdW-1:0] lockOwner,
  output lockStrobe_t [NumLocks-1:0] strobes
);

  for (genvar m = 0; m < NumLocks; m++) begin : g_lock
    logic [NumCores-1:0]    acqReq;
    logic [NumCores-1:0]    relReq;
    logic [IdW-1:0]         curOwner;
    logic                   ownerRel;
    logic [OWNER_W_MAX-1:0] winner;

    // Sort write requests aimed at this lock into claims and releases
    always_comb begin
      acqReq = '0;
      relReq = '0;
      for (int c = 0; c < NumCores; c++) begin
        if (coreValid[c] && coreWrite[c] &&
            (coreIndex[c*IxW +: IxW] == IxW'(m))) begin
          acqReq[c] = coreWData[c];
          relReq[c] = !coreWData[c];
        end
      end
    end

    assign curOwner = lockOwner[m*IdW +: IdW];

    // Only the release from the current holder counts
    always_comb begin
      ownerRel = 1'b0;
      for (int c = 0; c < NumCores; c++) begin
        if (relReq[c] && (curOwner == IdW'(c))) ownerRel = 1'b1;
      end
    end

    // Fixed priority: scan downward so the lowest claimant is kept
    always_comb begin
      winner = '0;
      for (int c = NumCores - 1; c >= 0; c--) begin
        if (acqReq[c]) winner = OWNER_W_MAX'(c);
      end
    end

    assign strobes[m] = '{take: (!lockHeld[m] && (|acqReq)),
                          drop: (lockHeld[m] && ownerRel),
                          who:  winner};
  end

endmodule

// File: rtl/mutex_dp.sv
module mutex_dp
  import mutex_pkg::*;
#(
  parameter int unsigned NumCores = MTX_CORES_DEF,
  parameter int unsigned NumLocks = MTX_LOCKS_DEF,
  parameter int unsigned IdW      = 2,
  parameter int unsigned IxW      = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lockStrobe_t [NumLocks-1:0] strobes,
  input  logic [NumCores-1:0]       coreValid,
  input  logic [NumCores-1:0]       coreWrite,
  input  logic [NumCores*IxW-1:0]   coreIndex,
  output logic [NumLocks-1:0]       lockHeld,
  output logic [NumLocks*IdW-1:0]   lockOwner,
  output logic [NumCores-1:0]       coreRValid,
  output logic [NumCores-1:0]       coreRData
);

  logic [NumCores-1:0] rdReq;
  logic [NumCores-1:0] rdHit;

  // Held bits and holder ids
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockHeld  <= '0;
      lockOwner <= '0;
    end else begin
      for (int m = 0; m < NumLocks; m++) begin
        if (strobes[m].take) begin
          lockHeld[m]               <= 1'b1;
          lockOwner[m*IdW +: IdW]   <= strobes[m].who[IdW-1:0];
        end else if (strobes[m].drop) begin
          lockHeld[m]               <= 1'b0;
          lockOwner[m*IdW +: IdW]   <= '0;
        end
      end
    end
  end

  // Ownership lookup, done against the state at the start of the cycle
  always_comb begin
    for (int c = 0; c < NumCores; c++) begin
      rdReq[c] = coreValid[c] && !coreWrite[c];
      rdHit[c] = 1'b0;
      for (int m = 0; m < NumLocks; m++) begin
        if (rdReq[c] && (coreIndex[c*IxW +: IxW] == IxW'(m)) &&
            lockHeld[m] && (lockOwner[m*IdW +: IdW] == IdW'(c)))
          rdHit[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreRValid <= '0;
      coreRData  <= '0;
    end else begin
      coreRValid <= rdReq;
      coreRData  <= rdHit;
    end
  end

endmodule

// File: rtl/mutex_bank.sv
module mutex_bank
  import mutex_pkg::*;
#(
  parameter int unsigned NumCores = MTX_CORES_DEF,
  parameter int unsigned NumLocks = MTX_LOCKS_DEF,
  localparam int unsigned IdW = (NumCores > 1) ? $clog2(NumCores) : 1,
  localparam int unsigned IxW = (NumLocks > 1) ? $clog2(NumLocks) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumCores-1:0]       coreValid,
  input  logic [NumCores-1:0]       coreWrite,
  input  logic [NumCores-1:0]       coreWData,
  input  logic [NumCores*IxW-1:0]   coreIndex,
  output logic [NumCores-1:0]       coreRValid,
  output logic [NumCores-1:0]       coreRData
);

  lockStrobe_t [NumLocks-1:0] strobes;
  logic [NumLocks-1:0]       lockHeld;
  logic [NumLocks*IdW-1:0]   lockOwner;

  mutex_ctrl #(
    .NumCores(NumCores), .NumLocks(NumLocks), .IdW(IdW), .IxW(IxW)
  ) uCtrl (
    .coreValid(coreValid),
    .coreWrite(coreWrite),
    .coreWData(coreWData),
    .coreIndex(coreIndex),
    .lockHeld (lockHeld),
    .lockOwner(lockOwner),
    .strobes  (strobes)
  );

  mutex_dp #(
    .NumCores(NumCores), .NumLocks(NumLocks), .IdW(IdW), .IxW(IxW)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .coreValid (coreValid),
    .coreWrite (coreWrite),
    .coreIndex (coreIndex),
    .lockHeld  (lockHeld),
    .lockOwner (lockOwner),
    .coreRValid(coreRValid),
    .coreRData (coreRData)
  );

endmodule

// File: rtl/mutex_bank_chk.sv
module mutex_bank_chk #(
  parameter int unsigned NumCores = 4,
  parameter int unsigned NumLocks = 8,
  parameter int unsigned IdW      = 2,
  parameter int unsigned IxW      = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NumCores-1:0]     coreValid,
  input logic [NumCores-1:0]     coreWrite,
  input logic [NumCores-1:0]     coreWData,
  input logic [NumCores*IxW-1:0] coreIndex,
  input logic [NumCores-1:0]     coreRValid,
  input logic [NumCores-1:0]     coreRData,
  input logic [NumLocks-1:0]     lockHeld,
  input logic [NumLocks*IdW-1:0] lockOwner
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic [NumLocks-1:0] anyAcq;
  logic [NumLocks-1:0] holderRel;
  logic [IdW-1:0]      lowAcq [NumLocks];
  logic [NumCores-1:0] ownRead;

  always_comb begin
    for (int m = 0; m < NumLocks; m++) begin
      anyAcq[m]    = 1'b0;
      holderRel[m] = 1'b0;
      lowAcq[m]    = '0;
      for (int c = NumCores - 1; c >= 0; c--) begin
        if (coreValid[c] && coreWrite[c] && (coreIndex[c*IxW +: IxW] == IxW'(m))) begin
          if (coreWData[c]) begin
            anyAcq[m] = 1'b1;
            lowAcq[m] = IdW'(c);
          end else if (lockOwner[m*IdW +: IdW] == IdW'(c)) begin
            holderRel[m] = 1'b1;
          end
        end
      end
    end
    for (int c = 0; c < NumCores; c++) begin
      ownRead[c] = 1'b0;
      for (int m = 0; m < NumLocks; m++) begin
        if (coreValid[c] && !coreWrite[c] && (coreIndex[c*IxW +: IxW] == IxW'(m)) &&
            lockHeld[m] && (lockOwner[m*IdW +: IdW] == IdW'(c)))
          ownRead[c] = 1'b1;
      end
    end
  end

  AST_FREE_AFTER_RESET: assert property (@(posedge clk) (rstN && !armed) |-> (lockHeld == '0)); // R1

  for (genvar c = 0; c < NumCores; c++) begin : g_core
    AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rstN || !armed)
      coreRValid[c] == $past(coreValid[c] && !coreWrite[c])); // R10
    AST_RESP_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rstN || !armed)
      coreRData[c] |-> $past(ownRead[c])); // R7
  end

  for (genvar m = 0; m < NumLocks; m++) begin : g_lock
    AST_TAKE_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rstN || !armed)
      $rose(lockHeld[m]) |-> $past(anyAcq[m])); // R2
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN || !armed)
      $rose(lockHeld[m]) |-> (lockOwner[m*IdW +: IdW] == $past(lowAcq[m]))); // R8
    AST_HOLDER_STABLE: assert property (@(posedge clk) disable iff (!rstN || !armed)
      (lockHeld[m] && $past(lockHeld[m])) |-> $stable(lockOwner[m*IdW +: IdW])); // R3
    AST_DROP_BY_HOLDER: assert property (@(posedge clk) disable iff (!rstN || !armed)
      $fell(lockHeld[m]) |-> $past(holderRel[m])); // R6
  end

endmodule

bind mutex_bank mutex_bank_chk #(
  .NumCores(NumCores), .NumLocks(NumLocks), .IdW(IdW), .IxW(IxW)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .coreValid (coreValid),
  .coreWrite (coreWrite),
  .coreWData (coreWData),
  .coreIndex (coreIndex),
  .coreRValid(coreRValid),
  .coreRData (coreRData),
  .lockHeld  (lockHeld),
  .lockOwner (lockOwner)
);

// File: tb/sim_mutex_bank.sv
module sim_mutex_bank;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0]    coreValid = '0;
  logic [NC-1:0]    coreWrite = '0;
  logic [NC-1:0]    coreWData = '0;
  logic [NC*IW-1:0] coreIndex = '0;
  logic [NC-1:0]    coreRValid;
  logic [NC-1:0]    coreRData;

  always #2 clk = ~clk;  // 250 MHz

  mutex_bank #(.NumCores(NC), .NumLocks(NL)) u0 (
    .clk(clk), .rstN(rstN),
    .coreValid(coreValid), .coreWrite(coreWrite), .coreWData(coreWData),
    .coreIndex(coreIndex), .coreRValid(coreRValid), .coreRData(coreRData)
  );

  // Scoreboard queues, one entry per driven cycle
  logic [NC-1:0] expVld[$];
  logic [NC-1:0] expDat[$];
  string         expTag[$];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference state
  bit mHeld[NL];
  int mOwner[NL];

  // Pending operation per core
  bit pV[NC];
  bit pW[NC];
  bit pD[NC];
  int pI[NC];

  task automatic checkVec(string tag, string what, logic [NC-1:0] act, logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic clearOps();
    for (int c = 0; c < NC; c++) begin
      pV[c] = 0; pW[c] = 0; pD[c] = 0; pI[c] = 0;
    end
  endtask

  task automatic opRead(int c, int idx);
    pV[c] = 1; pW[c] = 0; pD[c] = 0; pI[c] = idx;
  endtask

  task automatic opWrite(int c, bit d, int idx);
    pV[c] = 1; pW[c] = 1; pD[c] = d; pI[c] = idx;
  endtask

  // Driver: applies pending ops for one cycle, pushes expectation, updates model
  task automatic doCycle(string tag);
    logic [NC-1:0] ev;
    logic [NC-1:0] ed;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      coreValid[c] = pV[c];
      coreWrite[c] = pW[c];
      coreWData[c] = pD[c];
      coreIndex[c*IW +: IW] = IW'(pI[c]);
    end
    ev = '0;
    ed = '0;
    for (int c = 0; c < NC; c++) begin
      if (pV[c] && !pW[c]) begin
        ev[c] = 1'b1;
        ed[c] = mHeld[pI[c]] && (mOwner[pI[c]] == c);
      end
    end
    expVld.push_back(ev);
    expDat.push_back(ed);
    expTag.push_back(tag);
    for (int m = 0; m < NL; m++) begin
      int who;
      bit dropIt;
      who = -1;
      dropIt = 0;
      for (int c = 0; c < NC; c++) begin
        if (pV[c] && pW[c] && pI[c] == m) begin
          if (pD[c] && who < 0) who = c;
          if (!pD[c] && mHeld[m] && mOwner[m] == c) dropIt = 1;
        end
      end
      if (!mHeld[m] && who >= 0) begin
        mHeld[m] = 1; mOwner[m] = who;
      end else if (dropIt) begin
        mHeld[m] = 0; mOwner[m] = 0;
      end
    end
    clearOps();
  endtask

  // Monitor: one cycle after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expVld.size() > 0) begin
        logic [NC-1:0] ev;
        logic [NC-1:0] ed;
        string tg;
        ev = expVld.pop_front();
        ed = expDat.pop_front();
        tg = expTag.pop_front();
        checkVec({tg, " R10"}, "rvalid", coreRValid, ev);
        checkVec(tg, "rdata", coreRData & ev, ed);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < NL; m++) begin mHeld[m] = 0; mOwner[m] = 0; end
    clearOps();
    repeat (3) @(negedge clk);
    checkVec("R1", "rvalid in reset", coreRValid, '0);
    checkVec("R1", "rdata in reset", coreRData, '0);
    rstN = 1'b1;

    // R1: nothing held after reset
    for (int c = 0; c < NC; c++) opRead(c, 0);
    doCycle("R1");
    for (int c = 0; c < NC; c++) opRead(c, 7);
    doCycle("R1");

    // R2 / R9 / R7: claim then immediate read
    opWrite(1, 1, 2);                 doCycle("R2");
    opRead(1, 2); opRead(0, 2);       doCycle("R2 R9 R7");

    // R3: claim of a held lock by another core
    opWrite(0, 1, 2);                 doCycle("R3");
    opRead(0, 2); opRead(1, 2);       doCycle("R3");

    // R4: holder claims again
    opWrite(1, 1, 2);                 doCycle("R4");
    opRead(1, 2);                     doCycle("R4");

    // R6: release by non-holders
    opWrite(3, 0, 2); opWrite(0, 0, 2); doCycle("R6");
    opRead(1, 2); opRead(3, 2);       doCycle("R6");

    // R5: release by holder, then another core claims
    opWrite(1, 0, 2);                 doCycle("R5");
    opRead(1, 2);                     doCycle("R5");
    opWrite(2, 1, 2);                 doCycle("R5");
    opRead(2, 2); opRead(1, 2);       doCycle("R5");

    // R8: contention, lowest index wins
    opWrite(1, 1, 5); opWrite(2, 1, 5); opWrite(3, 1, 5); doCycle("R8");
    for (int c = 0; c < NC; c++) opRead(c, 5);
    doCycle("R8");
    opWrite(0, 1, 6); opWrite(3, 1, 6); doCycle("R8");
    opRead(0, 6); opRead(3, 6);       doCycle("R8");

    // R11: holder release and foreign claim in the same cycle
    opWrite(1, 0, 5); opWrite(3, 1, 5); opRead(0, 5); doCycle("R11");
    opRead(1, 5); opRead(3, 5);       doCycle("R11");
    opWrite(3, 1, 5);                 doCycle("R11");
    opRead(3, 5); opRead(1, 5);       doCycle("R11");

    // R12: parallel claims on distinct locks
    opWrite(0, 1, 1); opWrite(1, 1, 3); opWrite(2, 1, 4); opWrite(3, 1, 7); doCycle("R12");
    opRead(0, 1); opRead(1, 3); opRead(2, 4); opRead(3, 7); doCycle("R12");
    opRead(2, 3); opRead(0, 6); opRead(3, 5); opRead(1, 2); doCycle("R12");

    // R10: idle cycles give no response
    doCycle("R10");
    doCycle("R10");
    doCycle("R10");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule